// File: doc/BRIEF.md
# SPI Frame Timeout Watchdog

This block watches how long an SPI frame takes on the device master clock, so that a link whose chip-select is tied low for good can still regain alignment. The first accepted SCLK edge of a frame starts a cycle timer. The frame ends normally when the number of accepted SCLK edges reaches the configured frame length, or when chip-select is released. If the timeout is enabled and the final edge has not come within 2^TMO_LOG2 master clock cycles of the first one, the block issues a one-cycle reset pulse to the SPI shift and framing logic. It then returns to idle, so the very next SCLK edge is taken as bit one of a fresh frame.

The SCLK edge strobe arrives already synchronised to the master clock, one cycle high per edge. The cycle timer keeps running whether the timeout is enabled or not, and it saturates at the limit. Enabling the timeout late in a long frame therefore takes effect at once.

Top module: `spi_frame_watchdog`

## Requirements
- R1: While reset is held and after it is released, frame_rst_o and frame_busy_o are 0.
- R2: An SCLK strobe while cs_n_i is low and the block is idle starts a frame: frame_busy_o is 1 from the next cycle on, unless frame_bits_i is 1. Strobes while cs_n_i is high are ignored and leave frame_busy_o at 0.
- R3: A frame ends without a pulse on the strobe that brings the accepted edge count to frame_bits_i, and frame_busy_o is 0 in the next cycle. A frame_bits_i of 1 never raises frame_busy_o. A frame_bits_i of 0 means no length limit.
- R4: If the final strobe comes exactly 2^TMO_LOG2 cycles after the first strobe, the frame completes and no pulse is issued.
- R5: If the timeout is enabled and the frame has not completed, the pulse is issued. Counting the first strobe's cycle as 0, frame_rst_o is 1 in cycle 2^TMO_LOG2 + 1.
- R6: frame_rst_o is high for exactly one cycle, and frame_busy_o is 0 during that cycle.
- R7: A strobe that arrives in the pulse cycle starts a new frame.
- R8: A high cs_n_i during a frame ends it with no pulse. This holds even in the cycle in which the limit is reached.
- R9: With tmo_en_i low, no pulse is ever issued. If tmo_en_i goes high in a frame that is already at or past the limit, the pulse follows in the next cycle.
- R10: Frames that follow each other with cs_n_i held low are each timed from their own first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| sclk_edge_i | input | 1 | One-cycle strobe per SCLK edge, synchronised to clk_i |
| cs_n_i | input | 1 | Chip-select, active low |
| tmo_en_i | input | 1 | Timeout enable |
| frame_bits_i | input | BITS_W | Frame length in SCLK edges (0 = no length limit) |
| frame_rst_o | output | 1 | One-cycle reset pulse to the SPI frame logic |
| frame_busy_o | output | 1 | A frame is in progress |

## Verification
The timeout pulse and the start of the next frame can fall in the same cycle. This happens when a strobe arrives one cycle past the limit. The bench places a strobe in exactly that cycle and expects frame_rst_o and, one cycle later, frame_busy_o. A cs_n_i release timed to the limit cycle checks that the release wins over the timeout. A cycle-level reference function computes every expected value from the elapsed cycles and the edge count, for directed frames and for random strobe patterns.

// File: rtl/spi_wd_pkg.sv
// Package: shared types for the SPI frame timeout watchdog.
// Assumes: nothing beyond IEEE 1800-2017.
package spi_wd_pkg;

    // Frame state as seen by the watchdog.
    typedef enum logic {
        WD_IDLE = 1'b0,
        WD_RUN  = 1'b1
    } wd_state_e;

    // Control strobes from the frame controller to its counters.
    typedef struct packed {
        logic clr;      // clear both counters
        logic bit_inc;  // an SCLK edge is accepted this cycle
        logic tmr_en;   // advance the cycle timer
    } wd_ctl_t;

endpackage

// File: rtl/wd_bit_counter.sv
// Module: counts the accepted SCLK edges of the current frame and flags the
// strobe that completes it. The count saturates at its maximum.
// Assumes: clr_i wins over inc_i; run_i is high only while a frame is open.
// A frame_bits_i of 0 is never matched, because the next count is never 0.
module wd_bit_counter #(
    parameter int BITS_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              inc_i,
    input  logic              run_i,
    input  logic [BITS_W-1:0] frame_bits_i,
    output logic              last_o
);
    localparam logic [BITS_W-1:0] ONE = BITS_W'(1);

    logic [BITS_W-1:0] cnt_q;
    logic [BITS_W-1:0] cnt_nxt;

    // Purpose: work out the edge count after this strobe (1 at frame start).
    always_comb begin
        if (!run_i) begin
            cnt_nxt = ONE;
        end else if (cnt_q == '1) begin
            cnt_nxt = cnt_q;
        end else begin
            cnt_nxt = cnt_q + ONE;
        end
    end

    // Purpose: flag the strobe that reaches the configured frame length.
    assign last_o = inc_i && (cnt_nxt == frame_bits_i);

    // Purpose: hold the edge count of the current frame.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_nxt;
        end
    end
endmodule

// File: rtl/wd_cycle_timer.sv
// Module: counts master clock cycles since the first edge of a frame and
// saturates at the limit of 2^TMO_LOG2.
// Assumes: en_i is high in the first-edge cycle and while the frame is open.
// The timer therefore reads k in the k-th cycle after the first edge.
module wd_cycle_timer #(
    parameter int TMO_LOG2 = 15
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic en_i,
    output logic expired_o
);
    localparam int CNT_W = TMO_LOG2 + 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(1) << TMO_LOG2;

    logic [CNT_W-1:0] cnt_q;

    // Purpose: count frame cycles and stop at the limit instead of wrapping.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (en_i && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Purpose: report that the full window has elapsed.
    assign expired_o = (cnt_q == LIMIT);
endmodule

// File: rtl/wd_frame_ctrl.sv
// Module: frame state machine. It opens a frame on the first accepted edge
// and closes it on the last edge, on a chip-select release, or on a timeout.
// Only a timeout issues the registered one-cycle reset pulse.
// Assumes: the edge strobe is one clk_i cycle per SCLK edge. A chip-select
// release wins over a timeout in the same cycle.
module wd_frame_ctrl
    import spi_wd_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    sclk_edge_i,
    input  logic    cs_n_i,
    input  logic    tmo_en_i,
    input  logic    last_i,
    input  logic    expired_i,
    output wd_ctl_t ctl_o,
    output logic    busy_o,
    output logic    rst_pulse_o
);
    wd_state_e state_q;
    wd_state_e state_d;
    logic      accept;
    logic      fire;

    // Purpose: an edge counts only while chip-select is asserted.
    assign accept = sclk_edge_i && !cs_n_i;

    // Purpose: choose the next state, the counter controls and the timeout.
    always_comb begin
        state_d       = state_q;
        fire          = 1'b0;
        ctl_o.clr     = 1'b0;
        ctl_o.bit_inc = accept;
        ctl_o.tmr_en  = 1'b0;
        unique case (state_q)
            WD_IDLE: begin
                if (accept && !last_i) begin
                    state_d      = WD_RUN;
                    ctl_o.tmr_en = 1'b1;
                end else begin
                    ctl_o.clr = 1'b1;
                end
            end
            WD_RUN: begin
                ctl_o.tmr_en = 1'b1;
                if (cs_n_i || last_i) begin
                    state_d   = WD_IDLE;
                    ctl_o.clr = 1'b1;
                end else if (tmo_en_i && expired_i) begin
                    state_d   = WD_IDLE;
                    ctl_o.clr = 1'b1;
                    fire      = 1'b1;
                end
            end
            default: begin
                state_d   = WD_IDLE;
                ctl_o.clr = 1'b1;
            end
        endcase
    end

    // Purpose: register the state and the one-cycle reset pulse.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q     <= WD_IDLE;
            rst_pulse_o <= 1'b0;
        end else begin
            state_q     <= state_d;
            rst_pulse_o <= fire;
        end
    end

    // Purpose: report an open frame.
    assign busy_o = (state_q == WD_RUN);
endmodule

// File: rtl/spi_frame_watchdog.sv
// Module: top of the SPI frame timeout watchdog. It joins the frame
// controller, the edge counter and the cycle timer.
// Assumes: synchronous active-low reset, and an edge strobe already in the
// clk_i domain.
module spi_frame_watchdog
    import spi_wd_pkg::*;
#(
    parameter int TMO_LOG2 = 15,
    parameter int BITS_W   = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sclk_edge_i,
    input  logic              cs_n_i,
    input  logic              tmo_en_i,
    input  logic [BITS_W-1:0] frame_bits_i,
    output logic              frame_rst_o,
    output logic              frame_busy_o
);
    wd_ctl_t ctl;
    logic    last_edge;
    logic    expired;

    wd_frame_ctrl u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sclk_edge_i(sclk_edge_i),
        .cs_n_i     (cs_n_i),
        .tmo_en_i   (tmo_en_i),
        .last_i     (last_edge),
        .expired_i  (expired),
        .ctl_o      (ctl),
        .busy_o     (frame_busy_o),
        .rst_pulse_o(frame_rst_o)
    );

    wd_bit_counter #(.BITS_W(BITS_W)) u_bits (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clr_i       (ctl.clr),
        .inc_i       (ctl.bit_inc),
        .run_i       (frame_busy_o),
        .frame_bits_i(frame_bits_i),
        .last_o      (last_edge)
    );

    wd_cycle_timer #(.TMO_LOG2(TMO_LOG2)) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (ctl.clr),
        .en_i     (ctl.tmr_en),
        .expired_o(expired)
    );
endmodule

// File: rtl/spi_frame_watchdog_chk.sv
// Module: assertion checker for the watchdog, attached by bind. It sees
// only the ports, plus a saturating count of consecutive busy cycles.
// Assumes: the same parameters as the bound instance.
module spi_frame_watchdog_chk #(
    parameter int TMO_LOG2 = 15,
    parameter int BITS_W   = 10
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              sclk_edge_i,
    input logic              cs_n_i,
    input logic              tmo_en_i,
    input logic [BITS_W-1:0] frame_bits_i,
    input logic              frame_rst_o,
    input logic              frame_busy_o
);
    localparam int RW = TMO_LOG2 + 2;
    localparam logic [RW-1:0] LIMIT = RW'(1) << TMO_LOG2;

    logic [RW-1:0] run_cnt;

    // Purpose: count consecutive busy cycles, saturating.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !frame_busy_o) begin
            run_cnt <= '0;
        end else if (run_cnt != '1) begin
            run_cnt <= run_cnt + RW'(1);
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk_i)
        !rst_ni |=> (!frame_rst_o && !frame_busy_o));

    assert_frame_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!frame_busy_o && sclk_edge_i && !cs_n_i && frame_bits_i != BITS_W'(1)) |=> frame_busy_o);

    assert_cs_high_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!frame_busy_o && cs_n_i) |=> !frame_busy_o);

    assert_window_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tmo_en_i && $past(tmo_en_i) && frame_busy_o) |-> (run_cnt < LIMIT));

    assert_pulse_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_rst_o |=> !frame_rst_o);

    assert_idle_on_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_rst_o |-> !frame_busy_o);

    assert_cs_release_no_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_busy_o && cs_n_i) |=> (!frame_rst_o && !frame_busy_o));

    assert_disabled_no_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tmo_en_i |=> !frame_rst_o);
endmodule

bind spi_frame_watchdog spi_frame_watchdog_chk #(
    .TMO_LOG2(TMO_LOG2),
    .BITS_W  (BITS_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_edge_i (sclk_edge_i),
    .cs_n_i      (cs_n_i),
    .tmo_en_i    (tmo_en_i),
    .frame_bits_i(frame_bits_i),
    .frame_rst_o (frame_rst_o),
    .frame_busy_o(frame_busy_o)
);

// File: tb/spi_frame_watchdog_tb.sv
module spi_frame_watchdog_tb;
    localparam int TMO_LOG2 = 6;
    localparam int LIMIT    = 1 << TMO_LOG2;
    localparam int BITS_W   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_edge = 1'b0;
    logic cs_n = 1'b1;
    logic tmo_en = 1'b0;
    logic [BITS_W-1:0] frame_bits = 8'd8;
    logic frame_rst;
    logic frame_busy;

    always #2 clk = ~clk;

    spi_frame_watchdog #(.TMO_LOG2(TMO_LOG2), .BITS_W(BITS_W)) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .sclk_edge_i (sclk_edge),
        .cs_n_i      (cs_n),
        .tmo_en_i    (tmo_en),
        .frame_bits_i(frame_bits),
        .frame_rst_o (frame_rst),
        .frame_busy_o(frame_busy)
    );

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    done = 0;
    string phase = "R1 reset";

    // Reference state, built from the requirements.
    bit m_act = 0;
    int m_first = 0;
    int m_edges = 0;
    bit exp_rst = 0;
    bit exp_busy = 0;

    // Compute the outputs expected after this cycle's clock edge.
    function automatic void model_step(bit e, bit c, bit en, int bits);
        exp_rst = 0;
        if (!m_act) begin
            if (e && !c && bits != 1) begin
                m_act = 1; m_first = cyc; m_edges = 1;
            end
        end else if (c) begin
            m_act = 0;
        end else if (e && bits != 0 && m_edges + 1 == bits) begin
            m_act = 0;
        end else if (en && (cyc - m_first) >= LIMIT) begin
            m_act = 0; exp_rst = 1;
        end else if (e) begin
            m_edges++;
        end
        exp_busy = m_act;
    endfunction

    task automatic check(string tag, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    // Drive one cycle, then compare both outputs with the reference.
    task automatic step(bit e, bit c, bit en);
        @(negedge clk);
        sclk_edge = e; cs_n = c; tmo_en = en;
        model_step(e, c, en, int'(frame_bits));
        @(posedge clk);
        cyc++;
        #1;
        check(phase, frame_rst, exp_rst, "frame_rst_o");
        check(phase, frame_busy, exp_busy, "frame_busy_o");
    endtask

    task automatic idle(int n, bit c, bit en);
        for (int i = 0; i < n; i++) step(0, c, en);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20211));
        repeat (3) @(posedge clk);
        #1;
        check("R1", frame_rst, 1'b0, "frame_rst_o in reset");
        check("R1", frame_busy, 1'b0, "frame_busy_o in reset");
        @(negedge clk); rst_n = 1'b1;
        idle(2, 1, 1);

        phase = "R2 cs high edges";
        for (int i = 0; i < 4; i++) step(1, 1, 1);
        check("R2", frame_busy, 1'b0, "busy after cs-high edges");

        phase = "R3 normal frame";
        for (int i = 0; i < 8; i++) begin step(1, 0, 1); idle(2, 0, 1); end
        check("R3", frame_busy, 1'b0, "busy after last edge");

        phase = "R4 exact limit";
        for (int i = 0; i < 7; i++) step(1, 0, 1);
        idle(LIMIT - 7, 0, 1);
        step(1, 0, 1);
        check("R4", frame_rst, 1'b0, "no pulse at exact limit");
        idle(3, 0, 1);

        phase = "R5 one over";
        for (int i = 0; i < 7; i++) step(1, 0, 1);
        idle(LIMIT - 6, 0, 1);
        check("R5", frame_rst, 1'b1, "pulse one cycle over");
        phase = "R7 edge in pulse cycle";
        step(1, 0, 1);
        check("R6", frame_rst, 1'b0, "pulse width");
        check("R7", frame_busy, 1'b1, "new frame after pulse");
        phase = "R8 cs release";
        idle(1, 1, 1);
        check("R8", frame_busy, 1'b0, "cs release ends frame");

        phase = "R8 cs at limit";
        step(1, 0, 1);
        idle(LIMIT - 1, 0, 1);
        step(0, 1, 1);
        check("R8", frame_rst, 1'b0, "cs wins over timeout");
        idle(2, 0, 1);

        phase = "R9 disabled";
        step(1, 0, 0);
        idle(LIMIT + 40, 0, 0);
        check("R9", frame_rst, 1'b0, "no pulse when disabled");
        step(0, 0, 1);
        check("R9", frame_rst, 1'b1, "late enable fires");
        idle(2, 0, 1);

        phase = "R3 single-edge frames";
        frame_bits = 8'd1;
        for (int i = 0; i < 3; i++) begin
            step(1, 0, 1);
            check("R3", frame_busy, 1'b0, "one-bit frame never busy");
        end
        phase = "R3 open length";
        frame_bits = 8'd0;
        for (int i = 0; i <= LIMIT; i++) step(i % 5 == 0, 0, 1);
        check("R3", frame_rst, 1'b1, "open frame times out");
        idle(2, 0, 1);

        phase = "R10 back to back";
        frame_bits = 8'd4;
        for (int f = 0; f < 5; f++) begin
            for (int i = 0; i < 4; i++) begin step(1, 0, 1); idle(f * 5, 0, 1); end
        end
        check("R10", frame_busy, 1'b0, "idle after frames with cs low");

        phase = "R10 random";
        for (int s = 0; s < 24; s++) begin
            int gap;
            frame_bits = BITS_W'($urandom_range(0, 12));
            gap = $urandom_range(1, 20);
            for (int i = 0; i < 150; i++)
                step($urandom_range(1, gap) == 1, $urandom_range(0, 39) == 0,
                     $urandom_range(0, 19) != 0);
        end

        done = 1;
        finish_run();
    end
endmodule